// File: doc/BRIEF.md
# Network Controller Miscellaneous Configuration Register

This block is a small host-programmable control register for a network controller. It also owns the pins that depend on that register. It keeps four control bits:
- a gate for host writes into the address-PROM shadow store;
- the interrupt signalling mode;
- a converter power-control bit;
- the polarity of the converter-enable pin.

From these bits it drives the interrupt pad as an output-enable and data pair. It also drives the converter-enable output, which is forced to its idle level while the twisted-pair port is selected.

A 16-byte shadow store holds the station address bytes. After hard reset a load sequencer sits in state `LD_FILL`. Each strobe on the EEPROM load port writes one byte at an index that runs from 0 upward. The 16th byte takes the transition FILL->FULL into state `LD_FULL`. In `LD_FULL` the load port is ignored. The only transition back, FULL->FILL, is a hard reset.

Host reads of the PROM address range are always served from the shadow store. Host writes into it land only while the gate bit is set.

The interrupt pad has two modes:
- `IRQ_SHARED`: open-drain, active-low.
- `IRQ_DEDICATED`: push-pull, active-high.

Top module: `netctl_misc_cfg`

## Requirements
- R1: After hard reset, the control register reads 0x00 and every shadow byte reads 0x00. The pad outputs are irq_oe=0, irq_out=0 and cvt_en=0.
- R2: The control register sits at address 16, with the write gate in bit 0, the interrupt mode in bit 1, the converter control in bit 2 and the polarity in bit 3. A write stores bits 3:0. Bits 7:4 read 0. Addresses 17 to 31 read 0x00, and writes to them change nothing.
- R3: In LD_FILL, each ld_valid strobe stores ld_data at indices 0,1,...,15 in turn, whatever the gate bit holds. After the 16th byte, further strobes are ignored until a hard reset.
- R4: A host write to addresses 0 to 15 updates that shadow byte only when the gate bit is 1. When the gate is 0 the byte keeps its value.
- R5: When a load strobe and a host shadow write fall in the same cycle, the load byte is stored and the host write is dropped.
- R6: In mode 0 (IRQ_SHARED), a pending interrupt gives irq_oe=1 and irq_out=0. With no interrupt pending, irq_oe=0.
- R7: In mode 1 (IRQ_DEDICATED), irq_oe=1 always and irq_out equals the pending flag.
- R8: With port_tp=0 (AUI/GPSI active), the converter is asserted exactly when the control bit is 1. With port_tp=1 it is always deasserted.
- R9: cvt_en is high when asserted if polarity is 0, and low when asserted if polarity is 1. The deasserted level is the opposite.
- R10: soft_rst and stop_cmd leave the control bits, the shadow bytes and the load sequencer state unchanged.
- R11: irq_oe, irq_out and cvt_en are registered. A change of the pending flag, port select or control bits reaches them one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset pulse, no effect on this block's state |
| stop_cmd | input | 1 | Stop command pulse, no effect on this block's state |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_addr | input | 5 | Host byte address (0-15 shadow, 16 control) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Combinational read data for host_addr |
| ld_valid | input | 1 | EEPROM load byte strobe |
| ld_data | input | 8 | EEPROM load byte |
| irq_pending | input | 1 | Interrupt pending from the interrupt source logic |
| port_tp | input | 1 | 1 = twisted-pair port active, 0 = AUI/GPSI active |
| irq_oe | output | 1 | Interrupt pad output enable |
| irq_out | output | 1 | Interrupt pad output data |
| cvt_en | output | 1 | Converter-enable pin |

## Verification
The results fall into three timing groups:
- host_rdata follows host_addr in the same cycle;
- a register or shadow write shows in read data in the cycle after its strobe;
- the pad and converter pins change one clock after whatever feeds them.

Every expected item in the scoreboard carries the cycle in which it is due, counted in rising edges since the start. The monitor compares each item only in that cycle, half a period after the edge, and treats a stale item as a failure. For R11 the bench checks the old pad value in the cycle of the change and the new value one cycle later.

// File: rtl/netctl_misc_pkg.sv
package netctl_misc_pkg;
    localparam int CTRL_W = 4;

    // bit 0 = gate, bit 1 = irq mode, bit 2 = converter control, bit 3 = polarity
    typedef struct packed {
        logic cvt_pol;
        logic cvt_ctl;
        logic irq_mode;
        logic prom_we;
    } ctrl_bits_t;

    typedef enum logic {
        LD_FILL = 1'b0,
        LD_FULL = 1'b1
    } ld_state_t;

    typedef enum logic {
        IRQ_SHARED    = 1'b0,
        IRQ_DEDICATED = 1'b1
    } irq_mode_t;
endpackage

// File: rtl/misc_ctrl_reg.sv
module misc_ctrl_reg
    import netctl_misc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic                 soft_rst_i,
    input  logic                 stop_i,
    input  logic [CTRL_W-1:0]    wdata_i,
    output ctrl_bits_t           ctrl_o
);
    ctrl_bits_t ctrl_q;

    // Only the hard reset clears the bits; soft reset and stop are not in the list.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q <= ctrl_bits_t'(wdata_i);
        end
    end

    assign ctrl_o = ctrl_q;

    p_soft_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_rst_i || stop_i) && !wr_i) |=> $stable(ctrl_q));

    p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ctrl_q == $past(wdata_i)));
endmodule

// File: rtl/prom_shadow.sv
module prom_shadow
    import netctl_misc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              host_wr_i,
    input  logic [IDX_W-1:0]  host_idx_i,
    input  logic [DATA_W-1:0] host_data_i,
    input  logic              gate_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);
    ld_state_t state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic [DEPTH-1:0] wr_sel;
    logic ld_fire, host_fire;
    logic [IDX_W-1:0] wr_idx;
    logic [DATA_W-1:0] wr_byte;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and write steering
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ld_fire = 1'b0;
        unique case (state_q)
            LD_FILL: begin
                if (ld_valid_i) begin
                    ld_fire = 1'b1;
                    cnt_d   = cnt_q + 1'b1;
                    if (cnt_q == IDX_W'(DEPTH - 1)) begin
                        state_d = LD_FULL;
                    end
                end
            end
            LD_FULL: begin
                state_d = LD_FULL;
            end
        endcase
        host_fire = host_wr_i && gate_i && !ld_fire;
        wr_idx    = ld_fire ? cnt_q : host_idx_i;
        wr_byte   = ld_fire ? ld_data_i : host_data_i;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign wr_sel[g] = (ld_fire || host_fire) && (wr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_sel[i]) begin
                    mem_q[i] <= wr_byte;
                end
            end
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];

    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_FULL) |=> (state_q == LD_FULL));

    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !ld_fire) |=> $stable(mem_q));

    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fire |=> (mem_q[$past(cnt_q)] == $past(ld_data_i)));
endmodule

// File: rtl/pad_drive.sv
module pad_drive
    import netctl_misc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      irq_pend_i,
    input  irq_mode_t irq_mode_i,
    input  logic      cvt_ctl_i,
    input  logic      cvt_pol_i,
    input  logic      port_tp_i,
    output logic      irq_oe_o,
    output logic      irq_out_o,
    output logic      cvt_en_o
);
    logic oe_d, out_d, cvt_d;

    always_comb begin
        unique case (irq_mode_i)
            IRQ_SHARED: begin
                oe_d  = irq_pend_i;
                out_d = 1'b0;
            end
            IRQ_DEDICATED: begin
                oe_d  = 1'b1;
                out_d = irq_pend_i;
            end
        endcase
        cvt_d = (cvt_ctl_i && !port_tp_i) ^ cvt_pol_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_oe_o  <= 1'b0;
            irq_out_o <= 1'b0;
            cvt_en_o  <= 1'b0;
        end else begin
            irq_oe_o  <= oe_d;
            irq_out_o <= out_d;
            cvt_en_o  <= cvt_d;
        end
    end

    p_shared_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode_i == IRQ_SHARED && !irq_pend_i) |=> !irq_oe_o);

    p_shared_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode_i == IRQ_SHARED && irq_pend_i) |=> (irq_oe_o && !irq_out_o));

    p_dedicated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode_i == IRQ_DEDICATED) |=> (irq_oe_o && irq_out_o == $past(irq_pend_i)));

    p_tp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        port_tp_i |=> (cvt_en_o == $past(cvt_pol_i)));

    p_polarity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_tp_i && cvt_ctl_i) |=> (cvt_en_o == !$past(cvt_pol_i)));
endmodule

// File: rtl/netctl_misc_cfg.sv
module netctl_misc_cfg
    import netctl_misc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PROM_BYTES = 16,
    localparam int IDX_W     = $clog2(PROM_BYTES),
    localparam int ADDR_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stop_cmd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              irq_pending,
    input  logic              port_tp,
    output logic              irq_oe,
    output logic              irq_out,
    output logic              cvt_en
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(PROM_BYTES);

    ctrl_bits_t ctrl;
    logic in_prom, at_ctrl;
    logic [DATA_W-1:0] prom_byte;

    assign in_prom = (host_addr < CTRL_ADDR);
    assign at_ctrl = (host_addr == CTRL_ADDR);

    misc_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (host_wr && at_ctrl),
        .soft_rst_i (soft_rst),
        .stop_i     (stop_cmd),
        .wdata_i    (host_wdata[CTRL_W-1:0]),
        .ctrl_o     (ctrl)
    );

    prom_shadow #(.DATA_W(DATA_W), .DEPTH(PROM_BYTES)) u_prom (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid_i  (ld_valid),
        .ld_data_i   (ld_data),
        .host_wr_i   (host_wr && in_prom),
        .host_idx_i  (host_addr[IDX_W-1:0]),
        .host_data_i (host_wdata),
        .gate_i      (ctrl.prom_we),
        .rd_idx_i    (host_addr[IDX_W-1:0]),
        .rd_data_o   (prom_byte)
    );

    pad_drive u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pend_i (irq_pending),
        .irq_mode_i (irq_mode_t'(ctrl.irq_mode)),
        .cvt_ctl_i  (ctrl.cvt_ctl),
        .cvt_pol_i  (ctrl.cvt_pol),
        .port_tp_i  (port_tp),
        .irq_oe_o   (irq_oe),
        .irq_out_o  (irq_out),
        .cvt_en_o   (cvt_en)
    );

    always_comb begin
        if (in_prom) begin
            host_rdata = prom_byte;
        end else if (at_ctrl) begin
            host_rdata = {{(DATA_W - CTRL_W){1'b0}}, ctrl};
        end else begin
            host_rdata = '0;
        end
    end
endmodule

// File: tb/test_netctl_misc_cfg.sv
`timescale 1ns/100ps
module test_netctl_misc_cfg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, stop_cmd = 1'b0, host_wr = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0, host_rdata, ld_data = '0;
    logic ld_valid = 1'b0, irq_pending = 1'b0, port_tp = 1'b0;
    logic irq_oe, irq_out, cvt_en;

    always #2.5 clk = ~clk;

    netctl_misc_cfg i_netctl_misc_cfg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
        .irq_pending(irq_pending), .port_tp(port_tp),
        .irq_oe(irq_oe), .irq_out(irq_out), .cvt_en(cvt_en)
    );

    typedef struct {
        int         due;
        int         kind;   // 0 = host_rdata, 1 = {irq_oe, irq_out, cvt_en}
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc++;

    // monitor: compares each item in the cycle it is due
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                logic [7:0] got;
                if (sb[i].due <= cyc) begin
                    got = (sb[i].kind == 0) ? host_rdata : {5'b0, irq_oe, irq_out, cvt_en};
                    n_tests++;
                    if (sb[i].due < cyc || got !== sb[i].exp) begin
                        n_fail++;
                        $display("FAIL %s: kind %0d got %h expected %h", sb[i].tag, sb[i].kind, got, sb[i].exp);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic host_write(input logic [4:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic load_byte(input logic [7:0] d);
        ld_data = d; ld_valid = 1'b1;
        tick();
        ld_valid = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [7:0] v, input string tag);
        item_t it;
        host_addr = a;
        it.due = cyc; it.kind = 0; it.exp = v; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    task automatic expect_pad_now(input logic [2:0] v, input string tag);
        item_t it;
        it.due = cyc; it.kind = 1; it.exp = {5'b0, v}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_pad(input logic [2:0] v, input string tag);
        item_t it;
        it.due = cyc + 1; it.kind = 1; it.exp = {5'b0, v}; it.tag = tag;
        sb.push_back(it);
        tick();
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(5'd16, 8'h00, "R1 ctrl after reset");
        expect_rd(5'd5, 8'h00, "R1 shadow after reset");
        expect_pad(3'b000, "R1 pads after reset");

        // R3 fill with gate set, R5 collision at index 3
        host_write(5'd16, 8'h01);
        for (int i = 0; i < 3; i++) load_byte(8'hA0 + 8'(i));
        host_addr = 5'd3; host_wdata = 8'hEE; host_wr = 1'b1;
        ld_data = 8'hA3; ld_valid = 1'b1;
        tick();
        host_wr = 1'b0; ld_valid = 1'b0;
        for (int i = 4; i < 16; i++) load_byte(8'hA0 + 8'(i));
        expect_rd(5'd3, 8'hA3, "R5 load wins collision");
        expect_rd(5'd15, 8'hAF, "R3 last load byte");
        load_byte(8'h55);
        expect_rd(5'd0, 8'hA0, "R3 load ignored when full");
        expect_rd(5'd1, 8'hA1, "R3 byte 1 intact");

        // R4 write gate
        host_write(5'd7, 8'h77);
        expect_rd(5'd7, 8'h77, "R4 gated write lands");
        host_write(5'd16, 8'h00);
        host_write(5'd7, 8'h11);
        expect_rd(5'd7, 8'h77, "R4 write ignored with gate 0");

        // R2 register map
        host_write(5'd16, 8'hFF);
        expect_rd(5'd16, 8'h0F, "R2 reserved bits read 0");
        host_write(5'd20, 8'hFF);
        expect_rd(5'd20, 8'h00, "R2 unused address reads 0");
        expect_rd(5'd16, 8'h0F, "R2 unused address write no effect");
        host_write(5'd16, 8'h00);

        // R6 shared mode, R11 one-cycle delay
        tick();
        irq_pending = 1'b1;
        expect_pad_now(3'b000, "R11 old pad value before edge");
        expect_pad(3'b100, "R6 pending drives low");
        irq_pending = 1'b0;
        expect_pad_now(3'b100, "R11 old pad value before edge");
        expect_pad(3'b000, "R6 released when idle");

        // R7 dedicated mode
        host_write(5'd16, 8'h02);
        expect_pad(3'b100, "R7 driven low when idle");
        irq_pending = 1'b1;
        expect_pad(3'b110, "R7 driven high when pending");
        irq_pending = 1'b0;
        expect_pad(3'b100, "R7 back low");

        // R8 / R9 converter
        host_write(5'd16, 8'h06);
        expect_pad(3'b101, "R8 converter asserted high");
        host_write(5'd16, 8'h0E);
        expect_pad(3'b100, "R9 asserted low with polarity 1");
        host_write(5'd16, 8'h0A);
        expect_pad(3'b101, "R9 deasserted high with polarity 1");
        port_tp = 1'b1;
        expect_pad(3'b101, "R8 twisted pair idle level");
        host_write(5'd16, 8'h06);
        expect_pad(3'b100, "R8 twisted pair suppresses control");
        port_tp = 1'b0;
        expect_pad(3'b101, "R8 restored on AUI");

        // R10 soft reset and stop
        host_write(5'd16, 8'h0B);
        soft_rst = 1'b1; stop_cmd = 1'b1;
        tick();
        soft_rst = 1'b0; stop_cmd = 1'b0;
        expect_rd(5'd16, 8'h0B, "R10 ctrl kept");
        expect_rd(5'd7, 8'h77, "R10 shadow kept");
        load_byte(8'h99);
        expect_rd(5'd0, 8'hA0, "R10 loader stays full");

        // hard reset restarts everything
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        expect_rd(5'd16, 8'h00, "R1 ctrl after hard reset");
        expect_rd(5'd7, 8'h00, "R1 shadow after hard reset");
        expect_pad(3'b000, "R1 pads after hard reset");
        load_byte(8'h3C);
        expect_rd(5'd0, 8'h3C, "R3 fill restarts after hard reset");

        repeat (3) tick();
        if (sb.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        finish_run();
    end
endmodule